// File: doc/BRIEF.md
# Split-Stage Long-Interval Timer

This block emits a one-cycle pulse once every N clock cycles, where N is a 48-bit value that software or a sequencer supplies. It is built for trigger generators that need intervals from a single clock period up to days, with single-period resolution. Its cost is that a 48-bit count has to step at the full clock rate.

The count is split into two parts. A narrow fast stage (8 bits by default) decrements on every clock. A wide slow stage (40 bits by default) decrements only when the fast stage wraps from zero to all-ones. As a result, only the narrow stage and a one-bit "slow part is zero" flag sit in the full-rate path. A pulse fires when both parts are zero. In that same cycle both parts reload from the held preset.

A new preset is captured on a load request into a holding register. It takes effect only at the next terminal pulse, so the interval already running is never cut short or stretched. A preset of zero is stored as one.

Top module: `split_interval_timer`

## Requirements
- R1: With an effective preset N, consecutive rising edges of `tick_o` are exactly N clock cycles apart.
- R2: For N greater than one, `tick_o` is high for exactly one cycle per interval. For N equal to one, `tick_o` stays high on every cycle.
- R3: A preset value of zero behaves exactly like a preset of one.
- R4: A load request made while an interval is running does not change the length of that interval. The new value governs every interval that starts after the next pulse.
- R5: A load request made in the same cycle that `tick_o` is high does not affect the interval starting at that pulse. It governs the interval after that one.
- R6: When several load requests arrive within one interval, only the last one takes effect.
- R7: While `rst_ni` is low, `tick_o` is low and the held preset returns to `RST_PRESET`. After reset is released, the first pulse is seen after `RST_PRESET`-1 rising edges, and later pulses are `RST_PRESET` cycles apart until a load.
- R8: Intervals that begin, end or cross a wrap of the fast stage (for example 255, 256, 257 and 513) are exact. The slow stage moves only on a fast-stage wrap and never steps below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock; one count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_i | input | 48 | Interval length in clock cycles (0 is read as 1) |
| load_i | input | 1 | Captures `preset_i` into the holding register |
| tick_o | output | 1 | Terminal pulse |

## Verification
A corrupted fast stage shows up as an interval that is off by a few cycles, and this appears at the very next pulse. A slow stage that steps at the wrong moment shows up as an error of a multiple of 256 cycles. That error is seen only on intervals that cross a wrap, which is why presets just below, at and just above the wrap points are measured. A holding register that is mishandled changes which interval picks up a new value, so the bench measures the two intervals that follow each load, including a load that lands on the pulse cycle itself.

// File: rtl/sit_pkg.sv
package sit_pkg;
  localparam int FAST_W_DEF = 8;
  localparam int SLOW_W_DEF = 40;
endpackage

// File: rtl/sit_preset_hold.sv
module sit_preset_hold #(
  parameter int             W       = 48,
  parameter logic [W-1:0]   RST_VAL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] reload_o
);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] RST_EFF = (RST_VAL == '0) ? ONE : RST_VAL;

  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= RST_EFF;
    else if (load_i) hold_q <= (preset_i == '0) ? ONE : preset_i;
  end

  assign hold_o   = hold_q;
  assign reload_o = hold_q - ONE;

  // R3
  hold_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q != '0);

  // R6
  hold_follows_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (preset_i != '0) |=> hold_q == $past(preset_i));
endmodule

// File: rtl/sit_fast_stage.sv
module sit_fast_stage #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  output logic         zero_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_VAL;
    else if (reload_i) cnt_q <= reload_val_i;
    else               cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign wrap_o = zero_o && !reload_i;  // zero -> all-ones, carry into slow stage

  // R1
  fast_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(reload_val_i));

  // R1
  fast_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> cnt_q == W'($past(cnt_q) - 1'b1));
endmodule

// File: rtl/sit_slow_stage.sv
module sit_slow_stage #(
  parameter int           W       = 40,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         reload_i,
  input  logic [W-1:0] reload_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         zero_q;

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)  cnt_d = reload_val_i;
    else if (en_i) cnt_d = cnt_q - 1'b1;
  end

  // zero flag registered so only one bit reaches the fast path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_VAL;
      zero_q <= (RST_VAL == '0);
    end else begin
      cnt_q  <= cnt_d;
      zero_q <= (cnt_d == '0);
    end
  end

  assign zero_o = zero_q;

  // R8
  slow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !reload_i |=> $stable(cnt_q));

  // R8
  slow_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !reload_i |-> !zero_o);
endmodule

// File: rtl/split_interval_timer.sv
module split_interval_timer
  import sit_pkg::*;
#(
  parameter int                        FAST_W     = FAST_W_DEF,
  parameter int                        SLOW_W     = SLOW_W_DEF,
  parameter logic [FAST_W+SLOW_W-1:0]  RST_PRESET = 300
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [FAST_W+SLOW_W-1:0] preset_i,
  input  logic                     load_i,
  output logic                     tick_o
);
  localparam int              CNT_W   = FAST_W + SLOW_W;
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] RST_EFF = (RST_PRESET == '0) ? ONE : RST_PRESET;
  localparam logic [CNT_W-1:0] RST_CNT = RST_EFF - ONE;

  logic [CNT_W-1:0] hold, reload_val;
  logic             fast_zero, fast_wrap, slow_zero, terminal;

  sit_preset_hold #(.W(CNT_W), .RST_VAL(RST_EFF)) u_hold (
    .clk_i, .rst_ni, .load_i, .preset_i,
    .hold_o(hold), .reload_o(reload_val)
  );

  sit_fast_stage #(.W(FAST_W), .RST_VAL(RST_CNT[FAST_W-1:0])) u_fast (
    .clk_i, .rst_ni,
    .reload_i(terminal), .reload_val_i(reload_val[FAST_W-1:0]),
    .zero_o(fast_zero), .wrap_o(fast_wrap)
  );

  sit_slow_stage #(.W(SLOW_W), .RST_VAL(RST_CNT[CNT_W-1:FAST_W])) u_slow (
    .clk_i, .rst_ni,
    .en_i(fast_wrap), .reload_i(terminal),
    .reload_val_i(reload_val[CNT_W-1:FAST_W]),
    .zero_o(slow_zero)
  );

  assign terminal = fast_zero && slow_zero;
  assign tick_o   = terminal;

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (hold != ONE) |=> !tick_o);

  // R2
  unit_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (hold == ONE) |=> tick_o);
endmodule

// File: tb/split_interval_timer_tb.sv
module split_interval_timer_tb_top;
  localparam int NV = 8;
  localparam longint VP [NV] = '{1, 2, 0, 255, 256, 257, 513, 1000};
  localparam longint VE [NV] = '{1, 2, 1, 255, 256, 257, 513, 1000};
  localparam longint RSTP = 300;

  logic        clk = 0, rst_ni = 0, load_i = 0;
  logic [47:0] preset_i = '0;
  logic        tick_o;
  longint      cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          hung = 0;

  split_interval_timer #(.RST_PRESET(48'd300)) dut_i (
    .clk_i(clk), .rst_ni, .preset_i, .load_i, .tick_o
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output longint t);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!tick_o && guard < 5000);
    if (guard >= 5000) hung = 1;
    t = cyc;
  endtask

  task automatic do_load(input longint v);
    preset_i = 48'(v);
    load_i   = 1;
    @(negedge clk);
    load_i   = 0;
  endtask

  longint t0, t1, t2, trel;

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 tick low in reset", tick_o, 0);
    rst_ni = 1;
    trel = cyc;
    next_tick(t0);
    chk("R7 first pulse", t0 - trel, RSTP - 1);
    next_tick(t1);
    chk("R7 reset period", t1 - t0, RSTP);

    // R1 R3 R8: table
    for (int i = 0; i < NV; i++) begin
      do_load(VP[i]);
      next_tick(t0);
      next_tick(t1);
      chk($sformatf("R1/R3/R8 preset %0d", VP[i]), t1 - t0, VE[i]);
    end

    // R2: preset 1 keeps tick high; larger preset gives one-cycle pulse
    do_load(1);
    next_tick(t0);
    @(negedge clk);
    chk("R2 unit period high", tick_o, 1);
    do_load(5);
    next_tick(t0);
    next_tick(t0);
    @(negedge clk);
    chk("R2 one-cycle pulse", tick_o, 0);

    // R4: mid-interval load leaves current interval intact
    do_load(11);
    next_tick(t0);
    next_tick(t0);
    repeat (3) @(negedge clk);
    do_load(20);
    next_tick(t1);
    chk("R4 current interval kept", t1 - t0, 11);
    next_tick(t2);
    chk("R4 new interval", t2 - t1, 20);

    // R5: load on pulse cycle
    do_load(6);
    next_tick(t1);
    chk("R5 pulse-cycle load deferred", t1 - t2, 20);
    next_tick(t2);
    chk("R5 applied next", t2 - t1, 6);

    // R6: last of several loads wins
    do_load(9);
    do_load(13);
    next_tick(t1);
    chk("R6 running interval", t1 - t2, 6);
    next_tick(t2);
    chk("R6 last load wins", t2 - t1, 13);

    // R7: mid-run reset restores default preset
    repeat (4) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk("R7 tick low mid reset", tick_o, 0);
    rst_ni = 1;
    trel = cyc;
    next_tick(t0);
    chk("R7 first pulse after re-reset", t0 - trel, RSTP - 1);
    next_tick(t1);
    chk("R7 default period restored", t1 - t0, RSTP);

    if (hung) chk("watchdog tick wait", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule